// File: doc/BRIEF.md
# Iterative Shift-and-Add Unsigned Multiplier

The block multiplies two unsigned operands of `W` bits (8 by default) and returns a `2*W`-bit product. It does not use a wide array multiplier. It reuses one `W`-bit adder for `W` consecutive cycles. The product register has two halves, an upper half `hi` and a lower half `lo`.

When a start pulse arrives, the block does three things:

- It captures the multiplicand in its own register.
- It clears `hi`.
- It places the multiplier in `lo`.

Each iteration then inspects the least significant bit of `lo`. When that bit is set, the multiplicand is added to `hi`, and the carry out of that addition is kept. The carry, `hi` and `lo` are then shifted right together by one place. After the last iteration the full product sits in `{hi, lo}`.

A caller raises `start_i` for one cycle while the block is idle. It then waits for the single-cycle `done_o` pulse and reads `product_o`. That value is held until the next accepted start.

Top module: `shift_add_mul`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, `product_o` is 0, `busy_o` is 0 and `done_o` is 0.
- R2: A `start_i` sampled high at a clock edge while `busy_o` is low loads the operands. In the following cycle `busy_o` is 1 and `product_o` equals `{W'b0, mplier_i}`.
- R3: Exactly `W` iterations follow each accepted start. `done_o` is first high `W` clock edges after the loading edge, with `W` = 8 by default.
- R4: In one iteration where the LSB of `lo` is 0, nothing is added. `{hi, lo}` shifts right by one and a 0 enters the MSB of `hi`.
- R5: In one iteration where the LSB of `lo` is 1, the multiplicand is added to `hi` as a `W+1`-bit sum. The sum and `lo` are then shifted right by one. For example, 0xFF times 0xFF gives 0x7FFF after the first iteration.
- R6: The carry out of the addition enters bit `W-1` of `hi`, so results that use the top bit are exact. For example, 0xFF times 0xFF gives 0xFE01.
- R7: The final `product_o` equals the unsigned product of the operands. For example, 0x6D times 0xB6 gives 0x4D7E, so `hi` = 0x4D and `lo` = 0x7E.
- R8: `done_o` is high for exactly one cycle per operation. While `busy_o` is low and no start is accepted, `product_o` does not change.
- R9: A `start_i` that arrives while `busy_o` is high is ignored. This includes the cycle of the final iteration. The running operands, the latency and the result are left unchanged.
- R10: A zero multiplicand or a zero multiplier still takes `W` iterations and yields a product of 0.
- R11: A start is accepted in the same cycle that `done_o` is high, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted only when idle |
| mcand_i | input | W | Multiplicand operand, unsigned |
| mplier_i | input | W | Multiplier operand, unsigned |
| busy_o | output | 1 | High while iterations run |
| done_o | output | 1 | One-cycle pulse when the product is final |
| product_o | output | 2*W | Product register `{hi, lo}` |

## Verification
A new start request can coincide with the block's own final iteration. It can also coincide with the completion pulse. In the first case the request must be dropped. In the second case it must be taken.

The bench raises `start_i`, with different operands, in the cycle of the eighth iteration. It then checks three things: the original product is delivered, `done_o` comes on schedule, and `busy_o` falls afterwards.

It also raises `start_i` in the cycle where `done_o` is high. It then checks that the new multiplier appears in the low half one cycle later and that the second product is correct.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mul_state_e;
endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
#(
  parameter int W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic done_o
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  mul_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign load_o = start_i && (state_q == ST_IDLE);
  assign step_o = (state_q == ST_RUN);
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
          end
        end
        ST_RUN: begin
          if (cnt_q == LAST) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(step_o) && $past(cnt_q) == LAST)) // R3
    else $error("done without final iteration");

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o) // R8
    else $error("done longer than one cycle");

  AST_BUSY_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && start_i && cnt_q != LAST) |=> (step_o && cnt_q == $past(cnt_q) + 1'b1)) // R9
    else $error("start disturbed running count");
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] mcand_i,
  input  logic [W-1:0] mplier_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  logic [W-1:0] mcand_q, hi_q, lo_q;
  logic [W-1:0] addend, sum;
  logic         carry;

  // lo[0] gates the multiplicand; carry is kept for the shift into hi MSB
  always_comb begin
    addend       = lo_q[0] ? mcand_q : '0;
    {carry, sum} = {1'b0, hi_q} + {1'b0, addend};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
    end else if (load_i) begin
      mcand_q <= mcand_i;
      hi_q    <= '0;
      lo_q    <= mplier_i;
    end else if (step_i) begin
      hi_q <= {carry, sum[W-1:1]};
      lo_q <= {sum[0], lo_q[W-1:1]};
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;

  AST_SKIP_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && !lo_q[0]) |=> (hi_q == ($past(hi_q) >> 1))) // R4
    else $error("no-add iteration wrong");

  AST_ADD_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && lo_q[0]) |=>
      ({hi_q, lo_q[W-1]} == ({1'b0, $past(hi_q)} + {1'b0, $past(mcand_q)}))) // R6
    else $error("add iteration lost carry");

  AST_MCAND_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(mcand_q)) // R9
    else $error("multiplicand changed without load");
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [2*W-1:0] product_o
);
  logic         load, step;
  logic [W-1:0] hi, lo;

  mul_ctrl #(.W(W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .done_o (done_o)
  );

  mul_datapath #(.W(W)) u_dp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .step_i  (step),
    .mcand_i (mcand_i),
    .mplier_i(mplier_i),
    .hi_o    (hi),
    .lo_o    (lo)
  );

  assign busy_o    = step;
  assign product_o = {hi, lo};

  AST_LOAD_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && product_o == {{W{1'b0}}, $past(mplier_i)})) // R2
    else $error("load state wrong");

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(product_o)) // R8
    else $error("product moved while idle");

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o) // R3
    else $error("done while busy");
endmodule

// File: tb/tb_shift_add_mul.sv
`timescale 1ns/1ps
module tb_shift_add_mul;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   mcand = '0, mplier = '0;
  logic           busy, done;
  logic [2*W-1:0] product;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  shift_add_mul #(.W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .mcand_i(mcand), .mplier_i(mplier),
    .busy_o(busy), .done_o(done), .product_o(product)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // drive one-cycle start; returns at negedge after the loading edge
  task automatic kick(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    start = 1'b1; mcand = a; mplier = b;
    @(negedge clk);
    start = 1'b0;
  endtask

  // count negedges until done is seen
  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    chk("R1", "product in reset", product, 0);
    chk("R1", "busy in reset", busy, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "product after reset", product, 0);
    chk("R1", "busy after reset", busy, 0);
    chk("R1", "done after reset", done, 0);
  endtask

  task automatic t_mul(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    int n;
    kick(a, b);
    chk("R2", "busy after load", busy, 1);
    chk("R2", "product after load", product, {8'h00, b});
    wait_done(n);
    chk("R3", "latency", n, W);
    chk(req, "product", product, a * b);
  endtask

  task automatic t_first_step();
    int n;
    kick(8'hFF, 8'hFF);
    @(negedge clk);
    chk("R5", "after first add iteration", product, 16'h7FFF);
    wait_done(n);
    chk("R6", "carry product FFxFF", product, 16'hFE01);
    kick(8'h55, 8'h02);
    @(negedge clk);
    chk("R4", "after first skip iteration", product, 16'h0001);
    wait_done(n);
    chk("R7", "product 55x02", product, 16'h00AA);
  endtask

  task automatic t_hold();
    int n;
    logic [15:0] p;
    kick(8'h6D, 8'hB6);
    wait_done(n);
    chk("R7", "example product", product, 16'h4D7E);
    @(negedge clk);
    chk("R8", "done one cycle", done, 0);
    p = product;
    mcand = 8'h12; mplier = 8'h34;
    repeat (5) @(negedge clk);
    chk("R8", "product held idle", product, p);
    chk("R8", "done stays low", done, 0);
  endtask

  task automatic t_zero();
    t_mul(8'h00, 8'hA7, "R10");
    t_mul(8'hC3, 8'h00, "R10");
    t_mul(8'h00, 8'h00, "R10");
  endtask

  task automatic t_busy_start();
    int n;
    kick(8'h9B, 8'h4E);
    @(negedge clk);
    start = 1'b1; mcand = 8'h01; mplier = 8'h01;
    @(negedge clk);
    start = 1'b0;
    wait_done(n);
    chk("R9", "latency with mid start", n + 2, W);
    chk("R9", "product with mid start", product, 16'h9B * 16'h4E);
    kick(8'hE7, 8'h3C);
    repeat (W - 1) @(negedge clk);
    start = 1'b1; mcand = 8'h02; mplier = 8'h03;
    @(negedge clk);
    chk("R9", "done after last-iteration start", done, 1);
    start = 1'b0;
    chk("R9", "product after last-iteration start", product, 16'hE7 * 16'h3C);
    @(negedge clk);
    chk("R9", "idle after ignored start", busy, 0);
    chk("R9", "product kept", product, 16'hE7 * 16'h3C);
  endtask

  task automatic t_back_to_back();
    int n;
    kick(8'h21, 8'h43);
    wait_done(n);
    chk("R11", "first product", product, 16'h21 * 16'h43);
    start = 1'b1; mcand = 8'hF0; mplier = 8'h0F;
    @(negedge clk);
    start = 1'b0;
    chk("R11", "busy after start in done cycle", busy, 1);
    chk("R11", "load in done cycle", product, 16'h000F);
    wait_done(n);
    chk("R11", "second latency", n, W);
    chk("R11", "second product", product, 16'hF0 * 16'h0F);
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 6; i++) begin
      logic [W-1:0] a, b;
      a = W'(37 * i + 11);
      b = W'(8'hFF - 29 * i);
      t_mul(a, b, "R7");
    end
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_first_step();
    t_hold();
    t_zero();
    t_busy_start();
    t_back_to_back();
    t_sweep();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule